// File: doc/BRIEF.md
# Two-Write Chip Erase Command Recognizer

This block sits beside the control logic of an electrically erasable 64K x 8 memory and watches its write cycles. Each write consists of a 16-bit address, an 8-bit data byte and a write strobe. The block measures how many clock cycles the strobe stays high. It makes its decision in the cycle in which it first samples the strobe low again.

Two ways of starting a whole-chip erase are recognised:
- An unlock pair: first a short-pulse write of 0xAA to 0x5555, then directly a long-pulse write of 0x10 to 0x2AAA.
- A direct entry: the A9 high-voltage flag is set, address bit 10 is high, and address bits 8 and 11 are low while a strobe completes.

Any other completed write in program mode starts a byte program. The block reports the device operating mode. After an erase it moves to erase-verify, and after a program it moves to program-verify. Each verify mode is held until the power-down input, which acts as a synchronous reset.

Pulse widths are counted in clock cycles. The acceptance windows are parameters, so the real 50 us and 100 ms windows map onto any clock rate.

Top module: `chip_erase_seq`

## Requirements
- R1: During reset (rst_ni low), and in the clock cycle after the clock edge that samples pwr_down_i high, the outputs are: mode_o = READ, erase_start_o = 0, prog_start_o = 0. Power-down also drops any half-finished unlock sequence.
- R2: From READ the mode moves to PROG one cycle after hv_prog_i is seen high. In PROG it returns to READ when hv_prog_i is seen low, and this drops any half-finished unlock sequence. Strobes that complete outside PROG mode have no effect.
- R3: The strobe width is the number of rising clock edges at which wr_stb_i is high. A write is evaluated at the first edge that samples wr_stb_i low again, using addr_i, data_i and hv_a9_i at that edge. The resulting outputs appear right after that edge.
- R4: A write of data 0xAA to address 0x5555 with a width in [C1_MIN, C1_MAX] arms the unlock sequence. It raises no start pulse, and the mode stays PROG.
- R5: The next write after an arming write is of data 0x10 to address 0x2AAA with a width in [C2_MIN, C2_MAX]. It raises erase_start_o for exactly one cycle, with mode_o = ERASE in that cycle.
- R6: A command write whose width is outside its window does not count as a step. Neither does a second-step write that does not directly follow an arming write. Such a write is treated as an ordinary write (R8).
- R7: If hv_a9_i = 1, addr_i[10] = 1, addr_i[8] = 0 and addr_i[11] = 0 when a write completes in PROG, erase_start_o is raised for one cycle, whatever the data and width.
- R8: Any other completed write in PROG raises prog_start_o for one cycle, with mode_o = PROG in that cycle. prog_addr_o and prog_data_o then show that write's address and data.
- R9: In the cycle after an erase start the mode becomes EVERIFY. In the cycle after a program start it becomes PVERIFY. Both are held against strobes and against hv_prog_i until power-down.
- R10: mode_o uses these codes: READ = 0, PROG = 1, ERASE = 2, EVERIFY = 3, PVERIFY = 4.
- R11: The width counter saturates at its all-ones value instead of wrapping. A very long strobe therefore never lands inside a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_down_i | input | 1 | Power-down event, synchronous reset |
| hv_prog_i | input | 1 | Program-voltage present flag |
| hv_a9_i | input | 1 | High voltage on address bit 9 |
| wr_stb_i | input | 1 | Write strobe, active high |
| addr_i | input | 16 | Write address |
| data_i | input | 8 | Write data |
| erase_start_o | output | 1 | One-cycle chip erase start |
| prog_start_o | output | 1 | One-cycle byte program start |
| prog_addr_o | output | 16 | Address of the last programmed byte |
| prog_data_o | output | 8 | Data of the last programmed byte |
| mode_o | output | 3 | Current operating mode |

## Verification
The hardest state to reach from the ports is the armed state of the unlock tracker. It has no output of its own. Every write that fails to match ends in a sticky verify mode, so each trial can probe the armed state only once.

The bench therefore issues a power-down before every trial. It sweeps the first and the second pulse width across both sides of each window, and it also drives a strobe long enough to wrap an unsaturated counter back into the second window. Direct entry is swept over every combination of the A9 flag and address bits 8 to 11.

// File: rtl/chip_erase_seq_pkg.sv
package chip_erase_seq_pkg;

  typedef enum logic [2:0] {
    MODE_READ    = 3'd0,
    MODE_PROG    = 3'd1,
    MODE_ERASE   = 3'd2,
    MODE_EVERIFY = 3'd3,
    MODE_PVERIFY = 3'd4
  } mode_e;

  localparam logic [15:0] UNLOCK1_ADDR = 16'h5555;
  localparam logic [7:0]  UNLOCK1_DATA = 8'hAA;
  localparam logic [15:0] UNLOCK2_ADDR = 16'h2AAA;
  localparam logic [7:0]  UNLOCK2_DATA = 8'h10;

  typedef struct packed {
    logic direct_erase;
    logic step1_hit;
    logic step2_hit;
  } wr_class_t;

endpackage

// File: rtl/stb_width_meter.sv
module stb_width_meter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  output logic             fall_o,
  output logic [CNT_W-1:0] width_o
);
  logic             stb_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      stb_q <= stb_i;
      if (stb_i) begin
        if (!stb_q)        cnt_q <= {{(CNT_W-1){1'b0}}, 1'b1};
        else if (~&cnt_q)  cnt_q <= cnt_q + 1'b1;  // saturate
      end
    end
  end

  assign fall_o  = stb_q & ~stb_i;
  assign width_o = cnt_q;
endmodule

// File: rtl/wr_classifier.sv
module wr_classifier
  import chip_erase_seq_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned C1_MIN = 4,
  parameter int unsigned C1_MAX = 6,
  parameter int unsigned C2_MIN = 10,
  parameter int unsigned C2_MAX = 13
) (
  input  logic [15:0]      addr_i,
  input  logic [7:0]       data_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic             hv_a9_i,
  output wr_class_t        class_o
);
  localparam logic [CNT_W-1:0] W1_LO = CNT_W'(C1_MIN);
  localparam logic [CNT_W-1:0] W1_HI = CNT_W'(C1_MAX);
  localparam logic [CNT_W-1:0] W2_LO = CNT_W'(C2_MIN);
  localparam logic [CNT_W-1:0] W2_HI = CNT_W'(C2_MAX);

  logic in_w1, in_w2;

  always_comb begin
    in_w1 = (width_i >= W1_LO) && (width_i <= W1_HI);
    in_w2 = (width_i >= W2_LO) && (width_i <= W2_HI);
    class_o.direct_erase = hv_a9_i & addr_i[10] & ~addr_i[8] & ~addr_i[11];
    class_o.step1_hit    = in_w1 && addr_i == UNLOCK1_ADDR && data_i == UNLOCK1_DATA;
    class_o.step2_hit    = in_w2 && addr_i == UNLOCK2_ADDR && data_i == UNLOCK2_DATA;
  end
endmodule

// File: rtl/mode_tracker.sv
module mode_tracker
  import chip_erase_seq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pwr_down_i,
  input  logic        hv_prog_i,
  input  logic        fall_i,
  input  wr_class_t   class_i,
  input  logic [15:0] addr_i,
  input  logic [7:0]  data_i,
  output logic        erase_start_o,
  output logic        prog_start_o,
  output logic [15:0] prog_addr_o,
  output logic [7:0]  prog_data_o,
  output mode_e       mode_o
);
  mode_e mode_q;
  logic  armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q        <= MODE_READ;
      armed_q       <= 1'b0;
      erase_start_o <= 1'b0;
      prog_start_o  <= 1'b0;
      prog_addr_o   <= '0;
      prog_data_o   <= '0;
    end else begin
      erase_start_o <= 1'b0;
      prog_start_o  <= 1'b0;
      if (pwr_down_i) begin
        mode_q  <= MODE_READ;
        armed_q <= 1'b0;
      end else begin
        unique case (mode_q)
          MODE_READ: if (hv_prog_i) mode_q <= MODE_PROG;
          MODE_PROG: begin
            if (prog_start_o) begin
              mode_q <= MODE_PVERIFY;
            end else if (!hv_prog_i) begin
              mode_q  <= MODE_READ;
              armed_q <= 1'b0;
            end else if (fall_i) begin
              if (class_i.direct_erase || (armed_q && class_i.step2_hit)) begin
                mode_q        <= MODE_ERASE;
                erase_start_o <= 1'b1;
                armed_q       <= 1'b0;
              end else if (class_i.step1_hit) begin
                armed_q <= 1'b1;
              end else begin
                prog_start_o <= 1'b1;
                prog_addr_o  <= addr_i;
                prog_data_o  <= data_i;
                armed_q      <= 1'b0;
              end
            end
          end
          MODE_ERASE:   mode_q <= MODE_EVERIFY;
          MODE_EVERIFY: mode_q <= MODE_EVERIFY;
          MODE_PVERIFY: mode_q <= MODE_PVERIFY;
          default:      mode_q <= MODE_READ;
        endcase
      end
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/chip_erase_seq.sv
module chip_erase_seq
  import chip_erase_seq_pkg::*;
#(
  parameter int unsigned C1_MIN = 475,
  parameter int unsigned C1_MAX = 525,
  parameter int unsigned C2_MIN = 950000,
  parameter int unsigned C2_MAX = 1050000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pwr_down_i,
  input  logic        hv_prog_i,
  input  logic        hv_a9_i,
  input  logic        wr_stb_i,
  input  logic [15:0] addr_i,
  input  logic [7:0]  data_i,
  output logic        erase_start_o,
  output logic        prog_start_o,
  output logic [15:0] prog_addr_o,
  output logic [7:0]  prog_data_o,
  output logic [2:0]  mode_o
);
  localparam int unsigned WMAX  = (C1_MAX > C2_MAX) ? C1_MAX : C2_MAX;
  localparam int unsigned CNT_W = $clog2(WMAX + 2);  // all-ones stays above every window

  logic             fall;
  logic [CNT_W-1:0] width;
  wr_class_t        wr_class;
  mode_e            mode;

  stb_width_meter #(.CNT_W(CNT_W)) u_meter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stb_i   (wr_stb_i),
    .fall_o  (fall),
    .width_o (width)
  );

  wr_classifier #(
    .CNT_W (CNT_W),
    .C1_MIN(C1_MIN), .C1_MAX(C1_MAX),
    .C2_MIN(C2_MIN), .C2_MAX(C2_MAX)
  ) u_class (
    .addr_i  (addr_i),
    .data_i  (data_i),
    .width_i (width),
    .hv_a9_i (hv_a9_i),
    .class_o (wr_class)
  );

  mode_tracker u_track (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pwr_down_i    (pwr_down_i),
    .hv_prog_i     (hv_prog_i),
    .fall_i        (fall),
    .class_i       (wr_class),
    .addr_i        (addr_i),
    .data_i        (data_i),
    .erase_start_o (erase_start_o),
    .prog_start_o  (prog_start_o),
    .prog_addr_o   (prog_addr_o),
    .prog_data_o   (prog_data_o),
    .mode_o        (mode)
  );

  assign mode_o = mode;
endmodule

// File: rtl/chip_erase_seq_chk.sv
module chip_erase_seq_chk
  import chip_erase_seq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwr_down_i,
  input logic       erase_start_o,
  input logic       prog_start_o,
  input logic [2:0] mode_o
);
  AST_PWRDN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_down_i |=> (mode_o == MODE_READ && !erase_start_o && !prog_start_o)); // R1
  AST_START_FROM_PROG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_start_o || prog_start_o) |-> $past(mode_o) == MODE_PROG); // R2
  AST_ERASE_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_start_o |-> mode_o == MODE_ERASE); // R5
  AST_PROG_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |-> mode_o == MODE_PROG); // R8
  AST_START_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({erase_start_o, prog_start_o})); // R8
  AST_ERASE_TO_VERIFY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_start_o && !pwr_down_i) |=> mode_o == MODE_EVERIFY); // R9
  AST_PROG_TO_VERIFY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_start_o && !pwr_down_i) |=> mode_o == MODE_PVERIFY); // R9
  AST_EVERIFY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_EVERIFY && !pwr_down_i) |=> mode_o == MODE_EVERIFY); // R9
  AST_PVERIFY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_PVERIFY && !pwr_down_i) |=> mode_o == MODE_PVERIFY); // R9
  AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o <= 3'd4); // R10
endmodule

bind chip_erase_seq chip_erase_seq_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pwr_down_i    (pwr_down_i),
  .erase_start_o (erase_start_o),
  .prog_start_o  (prog_start_o),
  .mode_o        (mode_o)
);

// File: tb/chip_erase_seq_test.sv
module chip_erase_seq_test;
  localparam int C1_MIN = 4, C1_MAX = 6, C2_MIN = 10, C2_MAX = 13;

  logic clk = 1'b0, rst_ni = 1'b0, pwr_down = 1'b0, hv_prog = 1'b0, hv_a9 = 1'b0, stb = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic        erase_start, prog_start;
  logic [15:0] prog_addr;
  logic [7:0]  prog_data;
  logic [2:0]  mode;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic        es, ps;
  logic [2:0]  m0, m1;

  always #4 clk = ~clk;

  chip_erase_seq #(.C1_MIN(C1_MIN), .C1_MAX(C1_MAX), .C2_MIN(C2_MIN), .C2_MAX(C2_MAX)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_down_i(pwr_down), .hv_prog_i(hv_prog), .hv_a9_i(hv_a9),
    .wr_stb_i(stb), .addr_i(addr), .data_i(data), .erase_start_o(erase_start),
    .prog_start_o(prog_start), .prog_addr_o(prog_addr), .prog_data_o(prog_data), .mode_o(mode));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // strobe high for w edges; sample pulse/mode after the falling edge is seen, then one cycle later
  task automatic wr(input logic [15:0] a, input logic [7:0] d, input int w, input logic a9);
    @(negedge clk);
    addr = a; data = d; hv_a9 = a9; stb = 1'b1;
    repeat (w) @(negedge clk);
    stb = 1'b0;
    @(negedge clk);
    es = erase_start; ps = prog_start; m0 = mode;
    @(negedge clk);
    m1 = mode;
    hv_a9 = 1'b0;
  endtask

  task automatic pwrdn();
    @(negedge clk); pwr_down = 1'b1;
    @(negedge clk); pwr_down = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset mode", mode, 0);
    chk("R1 reset erase", erase_start, 0);
    chk("R1 reset prog", prog_start, 0);
    rst_ni = 1'b1;

    // R2: strobes in READ ignored
    wr(16'h5555, 8'hAA, 5, 1'b0);
    chk("R2 read ignore es", es, 0);
    chk("R2 read ignore ps", ps, 0);
    chk("R2 read stays", m1, 0);
    hv_prog = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R2 enter prog", mode, 1);

    // R4/R3: first-step width sweep
    for (int w = 1; w <= 8; w++) begin
      bit in1;
      in1 = (w >= C1_MIN && w <= C1_MAX);
      pwrdn();
      wr(16'h5555, 8'hAA, w, 1'b0);
      chk("R4 step1 no erase", es, 0);
      chk("R4 R6 step1 prog pulse", ps, in1 ? 0 : 1);
      chk("R4 step1 mode", m1, in1 ? 1 : 4);
      if (!in1) begin
        chk("R8 prog addr", prog_addr, 16'h5555);
        chk("R8 prog data", prog_data, 8'hAA);
      end
      wr(16'h2AAA, 8'h10, 11, 1'b0);
      chk("R5 R9 step2 erase", es, in1 ? 1 : 0);
      chk("R5 step2 mode", m0, in1 ? 2 : 4);
      chk("R9 verify", m1, in1 ? 3 : 4);
    end

    // R5/R6/R11: second-step width sweep including a wrapping length
    for (int w = 1; w <= 17; w++) begin
      int ww;
      bit in2;
      ww = (w == 17) ? 26 : w;
      in2 = (ww >= C2_MIN && ww <= C2_MAX);
      pwrdn();
      wr(16'h5555, 8'hAA, 5, 1'b0);
      wr(16'h2AAA, 8'h10, ww, 1'b0);
      chk(ww == 26 ? "R11 saturate erase" : "R5 R6 step2 erase", es, in2 ? 1 : 0);
      chk(ww == 26 ? "R11 saturate prog" : "R6 step2 prog", ps, in2 ? 0 : 1);
      chk("R9 step2 verify", m1, in2 ? 3 : 4);
    end

    // R6: second step without first
    pwrdn();
    wr(16'h2AAA, 8'h10, 11, 1'b0);
    chk("R6 lone step2 prog", ps, 1);
    chk("R6 lone step2 erase", es, 0);
    chk("R8 lone step2 addr", prog_addr, 16'h2AAA);
    chk("R8 lone step2 data", prog_data, 8'h10);

    // R4: repeated first step re-arms
    pwrdn();
    wr(16'h5555, 8'hAA, 4, 1'b0);
    wr(16'h5555, 8'hAA, 6, 1'b0);
    wr(16'h2AAA, 8'h10, 13, 1'b0);
    chk("R4 rearm erase", es, 1);

    // R1: power-down drops the armed step
    pwrdn();
    wr(16'h5555, 8'hAA, 5, 1'b0);
    pwrdn();
    wr(16'h2AAA, 8'h10, 11, 1'b0);
    chk("R1 pwrdn disarm", es, 0);
    chk("R1 pwrdn disarm prog", ps, 1);

    // R2: leaving program mode drops the armed step
    pwrdn();
    wr(16'h5555, 8'hAA, 5, 1'b0);
    @(negedge clk); hv_prog = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R2 leave prog", mode, 0);
    hv_prog = 1'b1;
    @(negedge clk); @(negedge clk);
    wr(16'h2AAA, 8'h10, 11, 1'b0);
    chk("R2 hv drop disarm", es, 0);

    // R7: direct entry over a9 and address bits 11..8
    for (int c = 0; c < 32; c++) begin
      logic [3:0] hb;
      logic a9;
      bit exp_e;
      hb = 4'(c);
      a9 = c[4];
      exp_e = a9 && hb[2] && !hb[0] && !hb[3];
      pwrdn();
      wr({4'h0, hb, 8'h3C}, 8'h5A, 2, a9);
      chk("R7 direct erase", es, exp_e ? 1 : 0);
      chk("R7 R8 direct else prog", ps, exp_e ? 0 : 1);
      chk("R9 direct verify", m1, exp_e ? 3 : 4);
    end

    // R9: erase-verify holds against hv_prog and strobes; R1 exits
    pwrdn();
    wr(16'h0400, 8'h00, 3, 1'b1);
    hv_prog = 1'b0;
    wr(16'h1234, 8'h77, 5, 1'b0);
    chk("R9 everify sticky", m1, 3);
    chk("R9 everify no prog", ps, 0);
    pwrdn();
    chk("R1 pwrdn to read", mode, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule